// File: doc/BRIEF.md
# SDRAM Low-Power Mode Sequencer

This block sits between an SDRAM command scheduler and the memory pins. It decides when to put the memory into a low-power state and when to bring it back out. While the memory is awake and ready, it offers a grant to the scheduler. When the scheduler stops requesting for long enough, the block takes over the pins. It precharges every bank, waits out the precharge time and then enters the low-power policy that is configured. There are three policies: self refresh, power-down and deep power-down.

Refresh ownership depends on the policy. In self refresh the memory refreshes itself, and the block only holds clock enable low. In power-down the block still owns refresh: on every refresh tick it wakes the memory, issues an auto refresh, waits the row-cycle time and drops back into power-down. Deep power-down loses the memory contents. On leaving it, the block flags that the memory has to be initialised again. A new request in any low-power state starts the exit sequence. The grant returns only once the memory is active and idle again.

Top module: `sdr_lowpower_seq`

## Requirements
- R1: Reset behaviour and mode 0. During reset and after it, `sd_cke` is 1, `sd_cmd` is NOP (code 0), `grant` is 1 and `reinit_req` is 0. With `cfg_mode` = 0 the block never leaves that state, however long the scheduler stays idle.
- R2: Mode selection. `cfg_mode` selects the policy: 0 = none, 1 = self refresh, 2 = power-down, 3 = deep power-down. The value is captured when an entry starts. Changes to it during an entry, a low-power period or an exit have no effect on the pins.
- R3: Idle timeout. With a nonzero mode, `cfg_timeout` code c gives D = c × 64 cycles (0, 64, 128 or 192). The precharge-all command appears in the cycle after the (D+1)-th consecutive granted cycle in which `acc_req` was sampled low. A sampled request, or mode 0, restarts the count.
- R4: Entry sequence. The block drives one cycle of PALL (code 1) with `sd_cke` high, then two cycles of NOP with `sd_cke` high. It then drives one entry cycle with `sd_cke` low: SREF (code 3) for self refresh, NOP for power-down, DPD (code 4) for deep power-down. `sd_cke` stays low from then on. A request arriving during the entry sequence does not abort it.
- R5: In self refresh and deep power-down the block ignores `ref_tick`. `sd_cke` stays low and `sd_cmd` stays NOP until a request is sampled.
- R6: Self-refresh and deep power-down exit. A request sampled in a low-power cycle raises `sd_cke` in the next cycle. The block then holds NOP with `grant` low for 8 cycles, the row-cycle time. `grant` returns in the cycle after that.
- R7: Power-down exit. A request sampled in a power-down cycle gives 1 cycle of NOP with `sd_cke` high and `grant` low, followed by a granted cycle.
- R8: Power-down refresh. A `ref_tick` sampled in a power-down cycle starts a refresh. The block drives 1 cycle of NOP with `sd_cke` high, then REF (code 2), then 7 NOP cycles. It then returns to awake if `acc_req` is high in the last of those NOP cycles. Otherwise it drives a NOP entry cycle with `sd_cke` low and goes back to power-down. A tick wins over a request sampled in the same cycle.
- R9: `reinit_req` is 1 in exactly one cycle: the first granted cycle after a deep power-down exit.
- R10: `grant` is 1 only while `sd_cke` is 1 and `sd_cmd` is NOP, and never during any entry, refresh or exit cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | Low-power policy select |
| cfg_timeout | input | 2 | Idle timeout code |
| acc_req | input | 1 | Scheduler has an access pending |
| ref_tick | input | 1 | Refresh interval elapsed |
| grant | output | 1 | Memory is active and idle; scheduler may proceed |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cmd | output | 3 | Command: 0 NOP, 1 PALL, 2 REF, 3 SREF, 4 DPD |
| reinit_req | output | 1 | Memory must be initialised again |

## Verification
Every result of this block is due a fixed number of cycles after the edge that samples its trigger:
- The precharge-all appears one cycle after the (D+1)-th idle sample.
- The entry cycle comes three cycles after the precharge-all.
- An exit raises clock enable one cycle after the request is sampled, and the grant follows 8 cycles later for self refresh or deep power-down, or 1 cycle later for power-down.
- A refresh command comes two cycles after the tick.

A behavioural model in the bench reacts at the same edge the design does and queues the whole expected pin sequence cycle by cycle. It is compared with the pins at every falling edge, half a cycle after each update, so every due cycle is hit exactly.

// File: rtl/sdr_lp_pkg.sv
package sdr_lp_pkg;

    typedef enum logic [2:0] {
        CMD_NOP  = 3'd0,
        CMD_PALL = 3'd1,
        CMD_REF  = 3'd2,
        CMD_SREF = 3'd3,
        CMD_DPD  = 3'd4
    } sd_cmd_e;

    typedef enum logic [1:0] {
        LPM_NONE  = 2'd0,
        LPM_SELF  = 2'd1,
        LPM_PDOWN = 2'd2,
        LPM_DEEP  = 2'd3
    } lp_mode_e;

    typedef enum logic [3:0] {
        ST_AWAKE = 4'd0,
        ST_PALL  = 4'd1,
        ST_TRP   = 4'd2,
        ST_ENTER = 4'd3,
        ST_LOW   = 4'd4,
        ST_EXIT  = 4'd5,
        ST_WAKE  = 4'd6,
        ST_RFSH  = 4'd7,
        ST_RWAIT = 4'd8
    } seq_state_e;

    typedef struct packed {
        logic    cke;
        sd_cmd_e cmd;
        logic    grant;
    } pin_drive_t;

    function automatic int unsigned idle_limit(input logic [1:0] code,
                                               input int unsigned step);
        return 32'(code) * step;
    endfunction

endpackage

// File: rtl/sdr_lp_idle_timer.sv
module sdr_lp_idle_timer
    import sdr_lp_pkg::*;
#(
    parameter int TO_STEP = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       idle,
    input  logic [1:0] code,
    output logic       expire
);
    localparam int MAX_LIMIT = 3 * TO_STEP;
    localparam int CW        = $clog2(MAX_LIMIT + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;

    assign limit  = CW'(idle_limit(code, TO_STEP));
    assign expire = en && idle && (cnt >= limit);

    always_ff @(posedge clk) begin
        if (rst || !(en && idle)) begin
            cnt <= '0;
        end else if (cnt < limit) begin
            cnt <= cnt + CW'(1);
        end
    end

    // R3
    cnt_origin_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt != '0) |-> $past(en && idle));

endmodule

// File: rtl/sdr_lp_fsm.sv
module sdr_lp_fsm
    import sdr_lp_pkg::*;
#(
    parameter int TRP = 3,
    parameter int TRC = 8,
    parameter int TXP = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] cfg_mode,
    input  logic       acc_req,
    input  logic       ref_tick,
    input  logic       expire,
    output seq_state_e st,
    output lp_mode_e   kind,
    output logic       reinit
);
    localparam int WMAX = (TRC > TRP) ? TRC : TRP;
    localparam int WW   = $clog2(WMAX + 1);

    seq_state_e    st_n;
    lp_mode_e      kind_n;
    logic [WW-1:0] wcnt, wcnt_n;
    logic          reinit_n;

    always_comb begin
        st_n     = st;
        kind_n   = kind;
        wcnt_n   = (wcnt != '0) ? wcnt - WW'(1) : '0;
        reinit_n = 1'b0;
        unique case (st)
            ST_AWAKE: begin
                if (expire) begin
                    st_n   = ST_PALL;
                    kind_n = lp_mode_e'(cfg_mode);
                end
            end
            ST_PALL: begin
                st_n   = ST_TRP;
                wcnt_n = WW'(TRP - 2);
            end
            ST_TRP:   if (wcnt == '0) st_n = ST_ENTER;
            ST_ENTER: st_n = ST_LOW;
            ST_LOW: begin
                if (kind == LPM_PDOWN && ref_tick) begin
                    st_n   = ST_WAKE;
                    wcnt_n = WW'(TXP - 1);
                end else if (acc_req) begin
                    st_n   = ST_EXIT;
                    wcnt_n = (kind == LPM_PDOWN) ? WW'(TXP - 1) : WW'(TRC - 1);
                end
            end
            ST_EXIT: begin
                if (wcnt == '0) begin
                    st_n     = ST_AWAKE;
                    reinit_n = (kind == LPM_DEEP);
                end
            end
            ST_WAKE:  if (wcnt == '0) st_n = ST_RFSH;
            ST_RFSH: begin
                st_n   = ST_RWAIT;
                wcnt_n = WW'(TRC - 2);
            end
            ST_RWAIT: if (wcnt == '0) st_n = acc_req ? ST_AWAKE : ST_ENTER;
            default:  st_n = ST_AWAKE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_AWAKE;
            kind   <= LPM_NONE;
            wcnt   <= '0;
            reinit <= 1'b0;
        end else begin
            st     <= st_n;
            kind   <= kind_n;
            wcnt   <= wcnt_n;
            reinit <= reinit_n;
        end
    end

    // R4
    pall_before_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ENTER && kind != LPM_PDOWN) |-> $past(st) == ST_TRP);

    // R8
    refresh_only_pdown_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RFSH) |-> (kind == LPM_PDOWN && $past(st) == ST_WAKE));

    // R9
    reinit_only_deep_chk: assert property (@(posedge clk) disable iff (rst)
        reinit |-> (kind == LPM_DEEP && st == ST_AWAKE && $past(st) == ST_EXIT));

    // R2
    kind_held_chk: assert property (@(posedge clk) disable iff (rst)
        (st != ST_AWAKE && $past(st) != ST_AWAKE) |-> $stable(kind));

endmodule

// File: rtl/sdr_lp_pin_dec.sv
module sdr_lp_pin_dec
    import sdr_lp_pkg::*;
(
    input  seq_state_e st,
    input  lp_mode_e   kind,
    output pin_drive_t drv
);
    always_comb begin
        drv = '{cke: 1'b1, cmd: CMD_NOP, grant: 1'b0};
        unique case (st)
            ST_AWAKE: drv.grant = 1'b1;
            ST_PALL:  drv.cmd   = CMD_PALL;
            ST_RFSH:  drv.cmd   = CMD_REF;
            ST_LOW:   drv.cke   = 1'b0;
            ST_ENTER: begin
                drv.cke = 1'b0;
                case (kind)
                    LPM_SELF: drv.cmd = CMD_SREF;
                    LPM_DEEP: drv.cmd = CMD_DPD;
                    default:  drv.cmd = CMD_NOP;
                endcase
            end
            default: drv = '{cke: 1'b1, cmd: CMD_NOP, grant: 1'b0};
        endcase
    end

endmodule

// File: rtl/sdr_lowpower_seq.sv
module sdr_lowpower_seq
    import sdr_lp_pkg::*;
#(
    parameter int TRP     = 3,
    parameter int TRC     = 8,
    parameter int TXP     = 1,
    parameter int TO_STEP = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] cfg_mode,
    input  logic [1:0] cfg_timeout,
    input  logic       acc_req,
    input  logic       ref_tick,
    output logic       grant,
    output logic       sd_cke,
    output logic [2:0] sd_cmd,
    output logic       reinit_req
);
    seq_state_e st;
    lp_mode_e   kind;
    logic       expire;
    logic       timer_en;
    logic       reinit;
    pin_drive_t drv;

    assign timer_en = (st == ST_AWAKE) && (cfg_mode != 2'd0);

    sdr_lp_idle_timer #(.TO_STEP(TO_STEP)) timer_i (
        .clk    (clk),
        .rst    (rst),
        .en     (timer_en),
        .idle   (!acc_req),
        .code   (cfg_timeout),
        .expire (expire)
    );

    sdr_lp_fsm #(.TRP(TRP), .TRC(TRC), .TXP(TXP)) fsm_i (
        .clk      (clk),
        .rst      (rst),
        .cfg_mode (cfg_mode),
        .acc_req  (acc_req),
        .ref_tick (ref_tick),
        .expire   (expire),
        .st       (st),
        .kind     (kind),
        .reinit   (reinit)
    );

    sdr_lp_pin_dec dec_i (
        .st   (st),
        .kind (kind),
        .drv  (drv)
    );

    assign grant      = drv.grant;
    assign sd_cke     = drv.cke;
    assign sd_cmd     = drv.cmd;
    assign reinit_req = reinit;

    // R10
    grant_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        grant |-> (sd_cke && sd_cmd == CMD_NOP));

    // R5
    low_cke_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_LOW) |-> (!sd_cke && sd_cmd == CMD_NOP));

    // R6
    wake_no_grant_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sd_cke) |-> !grant);

endmodule

// File: tb/sdr_lowpower_seq_tb_top.sv
module sdr_lowpower_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int TRP  = 3;
    localparam int TRC  = 8;
    localparam int TXP  = 1;
    localparam int STEP = 64;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] cfg_mode = 2'd0;
    logic [1:0] cfg_timeout = 2'd0;
    logic       acc_req = 1'b0;
    logic       ref_tick = 1'b0;
    logic       grant, sd_cke, reinit_req;
    logic [2:0] sd_cmd;

    sdr_lowpower_seq #(.TRP(TRP), .TRC(TRC), .TXP(TXP), .TO_STEP(STEP)) dut_i (
        .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_timeout(cfg_timeout),
        .acc_req(acc_req), .ref_tick(ref_tick), .grant(grant), .sd_cke(sd_cke),
        .sd_cmd(sd_cmd), .reinit_req(reinit_req)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    typedef struct {
        bit    cke;
        int    cmd;
        bit    grant;
        bit    reinit;
        string tag;
    } exp_t;

    exp_t q[$];
    exp_t cur;
    int   rest;        // 0 awake, 1 asleep, 2 after refresh
    int   kind;
    int   idle_run;
    bit   cur_q;
    bit   reinit_due;
    bit   started = 0;
    bit   done = 0;
    int   checks = 0;
    int   errors = 0;

    function automatic exp_t mk(bit cke, int cmd, bit g, bit r, string tag);
        exp_t e;
        e.cke = cke; e.cmd = cmd; e.grant = g; e.reinit = r; e.tag = tag;
        return e;
    endfunction

    // Behavioural reference: reacts at the same edge, queues whole pin sequences
    always @(posedge clk) begin
        started <= 1'b1;
        if (rst) begin
            q.delete();
            rest = 0; idle_run = 0; kind = 0; cur_q = 0; reinit_due = 0;
            cur = mk(1, 0, 1, 0, "R1");
        end else begin
            if (cur_q && q.size() == 0 && rest == 2) begin
                if (acc_req) rest = 0;
                else begin
                    q.push_back(mk(0, 0, 0, 0, "R8"));
                    rest = 1;
                end
            end else if (!cur_q) begin
                if (rest == 0) begin
                    if (cfg_mode != 0 && !acc_req) begin
                        idle_run++;
                        if (idle_run >= int'(cfg_timeout) * STEP + 1) begin  // R3
                            kind = int'(cfg_mode);                           // R2
                            idle_run = 0;
                            rest = 1;
                            q.push_back(mk(1, 1, 0, 0, "R4"));
                            repeat (TRP - 1) q.push_back(mk(1, 0, 0, 0, "R4"));
                            q.push_back(mk(0, (kind == 1) ? 3 : ((kind == 3) ? 4 : 0), 0, 0, "R4"));
                        end
                    end else begin
                        idle_run = 0;
                    end
                end else if (rest == 1) begin
                    if (kind == 2 && ref_tick) begin
                        repeat (TXP) q.push_back(mk(1, 0, 0, 0, "R8"));
                        q.push_back(mk(1, 2, 0, 0, "R8"));
                        repeat (TRC - 1) q.push_back(mk(1, 0, 0, 0, "R8"));
                        rest = 2;
                    end else if (acc_req) begin
                        if (kind == 2) repeat (TXP) q.push_back(mk(1, 0, 0, 0, "R7"));
                        else repeat (TRC) q.push_back(mk(1, 0, 0, 0, "R6"));
                        reinit_due = (kind == 3);
                        rest = 0;
                    end
                end
            end
            if (q.size() > 0) begin
                cur = q.pop_front();
                cur_q = 1;
            end else begin
                cur_q = 0;
                if (rest == 0) begin
                    cur = mk(1, 0, 1, reinit_due, reinit_due ? "R9" : "R1");
                    reinit_due = 0;
                end else begin
                    cur = mk(0, 0, 0, 0, (kind == 2) ? "R8" : "R5");
                end
            end
        end
    end

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s at %0t: actual %0d expected %0d", tag, what, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (started && !done) begin
            chk(sd_cke == cur.cke, cur.tag, "sd_cke", int'(sd_cke), int'(cur.cke));
            chk(int'(sd_cmd) == cur.cmd, cur.tag, "sd_cmd", int'(sd_cmd), cur.cmd);
            chk(grant == cur.grant, {cur.tag, "/R10"}, "grant", int'(grant), int'(cur.grant));
            chk(reinit_req == cur.reinit, {cur.tag, "/R9"}, "reinit_req", int'(reinit_req), int'(cur.reinit));
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick_pulse();
        ref_tick = 1'b1;
        cyc(1);
        ref_tick = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        cyc(3);
        rst = 1'b0;
        // R1: mode 0 stays awake while idle
        cyc(40);
        // R4/R5: self refresh, no timeout; ticks ignored; R2: mode change while asleep
        cfg_mode = 2'd1; cfg_timeout = 2'd0;
        cyc(20);
        tick_pulse();
        cyc(5);
        cfg_mode = 2'd2;
        cyc(5);
        acc_req = 1'b1;                 // R6 exit
        cyc(20);
        // R3: 64-cycle timeout restarted by a single request
        cfg_timeout = 2'd1;
        acc_req = 1'b0;
        cyc(30);
        acc_req = 1'b1;
        cyc(1);
        acc_req = 1'b0;
        cyc(80);
        // R8: refresh in power-down, back to sleep
        tick_pulse();
        cyc(20);
        // R8: tick and request together, tick wins
        ref_tick = 1'b1; acc_req = 1'b1;
        cyc(1);
        ref_tick = 1'b0;
        cyc(20);
        acc_req = 1'b0;
        cyc(80);
        // R8: request arrives during refresh wait
        tick_pulse();
        cyc(4);
        acc_req = 1'b1;
        cyc(12);
        cfg_timeout = 2'd0;
        acc_req = 1'b0;
        cyc(10);
        // R7: power-down exit
        acc_req = 1'b1;
        cyc(6);
        // R9: deep power-down with 128-cycle timeout
        cfg_mode = 2'd3; cfg_timeout = 2'd2;
        acc_req = 1'b0;
        cyc(140);
        tick_pulse();
        cyc(5);
        acc_req = 1'b1;
        cyc(15);
        // R4/R10: 192-cycle timeout, request lands during entry sequence
        cfg_mode = 2'd1; cfg_timeout = 2'd3;
        acc_req = 1'b0;
        cyc(194);
        acc_req = 1'b1;
        cyc(30);
        // R2: changes while awake with requests pending; then mode 0 idle
        cfg_mode = 2'd0;
        acc_req = 1'b0;
        cyc(30);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

endmodule